// File: doc/BRIEF.md
# Multiframe Framing-Bit Message Inserter

This block produces the framing bit of every outgoing T1 frame for a transmitter running the twelve-frame superframe format with a 72-frame message multiframe on top of it. A one-cycle `frame_tick` from the transmit timing asks for the next framing bit. Even-indexed frames (frame 0, 2, 4, ...) carry the terminal framing pattern, a plain 1,0,1,0 alternation that host data never touches. Odd-indexed frames carry the signalling-framing positions. Their content comes from six host bytes per multiframe, one per superframe.

The host feeds bytes through a ready/valid byte port. A single staging register sits behind the port. `host_ready` is high while that register is empty, so it rises again at every superframe boundary once the staged byte has been consumed. A byte staged during superframe s-1 becomes the message for superframe s at the boundary tick of superframe s. Its six low bits are then sent least significant bit first in the six odd frames of that superframe. The bytes for superframes 0 and 1 normally hold the sync pattern. The remaining four carry spoiler, maintenance, alarm and channel fields, as the host chooses.

If no byte is staged when a superframe begins, the block resends the last byte it used for that superframe slot and raises `underrun` for that superframe.

Top module: `fs_msg_framer`

## Requirements
- R1: While `rst_n` is low, `fbit`, `frame_idx`, `fs_pos` and `underrun` are 0 and `host_ready` is 1.
- R2: In a frame with an even index f, `fbit` is 1 when (f/2) is even and 0 otherwise, whatever the host writes.
- R3: In frame 12·s+2·j+1 (superframe s, j = 0..5), `fbit` equals bit j of the message active for superframe s.
- R4: `host_ready` is 1 exactly while the staging register is empty. A byte is taken in a cycle where `host_valid` and `host_ready` are both 1, and `host_ready` is 0 in the next cycle.
- R5: On the tick of a frame whose index is a multiple of 12 (superframe s begins), a staged byte becomes the active message for s. It is also stored as the history for slot s, the staging register empties, and `host_ready` is 1 in the next cycle unless a byte is taken in that same cycle.
- R6: Bits 7 and 6 of `host_data` have no effect on any output.
- R7: If nothing is staged when superframe s begins, the history byte of slot s is resent and `underrun` is 1 from that tick until the next superframe start. When a byte was staged, `underrun` is 0 for that superframe. A byte taken in the boundary cycle itself counts for the next slot.
- R8: After reset the history of slots 0 and 1 is 6'b111000 (the sync bits 0,0,0,1,1,1 in sending order), and the history of slots 2 to 5 is 0.
- R9: `frame_idx` gives the index 0..71 of the frame whose bit is on `fbit`, counting up by one per tick and wrapping from 71 to 0. `fs_pos` is 1 exactly for odd indices.
- R10: `fbit`, `frame_idx` and `fs_pos` change only in the cycle after a `frame_tick` and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle request for the next frame's framing bit |
| host_valid | input | 1 | Host offers a message byte |
| host_data | input | 8 | Message byte; bits 5..0 used, bits 7..6 ignored |
| host_ready | output | 1 | Staging register empty, a byte will be taken |
| fbit | output | 1 | Framing bit of the current frame |
| frame_idx | output | 7 | Multiframe index of the frame on `fbit` |
| fs_pos | output | 1 | Current frame is a signalling-framing position |
| underrun | output | 1 | Current superframe resends a stale byte |

## Verification
`fbit`, `frame_idx` and `fs_pos` belong to the frame of a tick and settle one clock after the rising edge that sampled that tick. `underrun` and the new active message follow a boundary tick by the same single clock. `host_ready` falls one clock after an accepting edge and rises one clock after the boundary edge that empties the staging register. The bench drives stimulus on falling edges and advances its behavioural model on the rising edge. It then compares every output at the next falling edge, so each result is checked in exactly the cycle it is due, and in every cycle where it must hold.

// File: rtl/fsmi_pkg.sv
// Package: shared types and helpers for the multiframe framing-bit inserter.
// Assumes message slots are sent least significant bit first.
package fsmi_pkg;

    // Kind of framing position a frame occupies.
    typedef enum logic {
        FB_TERMINAL = 1'b0,
        FB_SIGNAL   = 1'b1
    } fb_kind_e;

    // Sync-word for a slot of 'bits' message bits: first half zeros, second half ones,
    // in sending order (LSB first), so the value has ones in its upper half.
    function automatic logic [63:0] sync_word(input int bits);
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < bits; i++) begin
            w[i] = (i >= bits / 2);
        end
        return w;
    endfunction

endpackage

// File: rtl/fsmi_frame_seq.sv
// Module: frame sequencer.
// Tracks the position of the next frame inside the superframe and the multiframe,
// and the phase of the terminal framing alternation. Advances only on tick.
// Assumes FRAMES_PER_SF is even, so odd positions are the signalling positions.
module fsmi_frame_seq #(
    parameter int FRAMES_PER_SF = 12,
    parameter int SF_PER_MF     = 6,
    localparam int FRAMES_PER_MF = FRAMES_PER_SF * SF_PER_MF,
    localparam int MSG_BITS      = FRAMES_PER_SF / 2,
    localparam int IDX_W         = $clog2(FRAMES_PER_MF),
    localparam int SF_W          = $clog2(SF_PER_MF),
    localparam int POS_W         = $clog2(FRAMES_PER_SF),
    localparam int SEL_W         = $clog2(MSG_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [IDX_W-1:0] frame_num,
    output logic [SF_W-1:0]  sf_num,
    output logic [SEL_W-1:0] bit_sel,
    output logic             is_fs,
    output logic             sf_start,
    output logic             ft_val
);

    logic [POS_W-1:0] pos_q;
    logic [SF_W-1:0]  sf_q;
    logic [IDX_W-1:0] frm_q;
    logic             ft_q;

    logic pos_last;
    logic sf_last;
    logic frm_last;

    // Purpose: detect the last position of each counter.
    always_comb begin
        pos_last = (pos_q == POS_W'(FRAMES_PER_SF - 1));
        sf_last  = (sf_q  == SF_W'(SF_PER_MF - 1));
        frm_last = (frm_q == IDX_W'(FRAMES_PER_MF - 1));
    end

    // Purpose: step the frame position within the superframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= pos_last ? '0 : pos_q + 1'b1;
        end
    end

    // Purpose: step the superframe number within the multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q <= '0;
        end else if (tick && pos_last) begin
            sf_q <= sf_last ? '0 : sf_q + 1'b1;
        end
    end

    // Purpose: step the frame index within the multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else if (tick) begin
            frm_q <= frm_last ? '0 : frm_q + 1'b1;
        end
    end

    // Purpose: toggle the terminal framing value after every terminal position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ft_q <= 1'b1;
        end else if (tick && !pos_q[0]) begin
            ft_q <= !ft_q;
        end
    end

    // Purpose: derive the position outputs used by the rest of the block.
    always_comb begin
        frame_num = frm_q;
        sf_num    = sf_q;
        is_fs     = pos_q[0];
        bit_sel   = SEL_W'(pos_q >> 1);
        sf_start  = tick && (pos_q == '0);
        ft_val    = ft_q;
    end

endmodule

// File: rtl/fsmi_slot_store.sv
// Module: message slot store.
// Holds one staging byte from the host and a per-slot history of the last
// message used in each superframe. At a superframe start it selects the
// message for that superframe: the staged byte if present, else the history.
// Assumes sf_start is a single-cycle pulse and sf_num names the starting superframe.
module fsmi_slot_store #(
    parameter int SF_PER_MF  = 6,
    parameter int MSG_BITS   = 6,
    parameter int BYTE_W     = 8,
    parameter int SYNC_SLOTS = 2,
    localparam int SF_W      = $clog2(SF_PER_MF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sf_start,
    input  logic [SF_W-1:0]     sf_num,
    input  logic                wr_valid,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                wr_ready,
    output logic [MSG_BITS-1:0] active_msg,
    output logic                underrun
);

    import fsmi_pkg::*;

    localparam logic [MSG_BITS-1:0] SYNC_MSG = MSG_BITS'(sync_word(MSG_BITS));

    logic [MSG_BITS-1:0] stage_q;
    logic                stage_vld_q;
    logic [MSG_BITS-1:0] hist_q [SF_PER_MF];
    logic [MSG_BITS-1:0] hist_sel;
    logic [MSG_BITS-1:0] active_q;
    logic                underrun_q;
    logic                accept;
    logic                unused_upper;

    // Purpose: upper data bits carry no message content.
    assign unused_upper = ^wr_data[BYTE_W-1:MSG_BITS];

    // Purpose: handshake, a byte is taken only into an empty stage.
    always_comb begin
        wr_ready = !stage_vld_q;
        accept   = wr_valid && !stage_vld_q;
    end

    // Purpose: capture a host byte and empty the stage at a superframe start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q     <= '0;
            stage_vld_q <= 1'b0;
        end else if (accept) begin
            stage_q     <= wr_data[MSG_BITS-1:0];
            stage_vld_q <= 1'b1;
        end else if (sf_start) begin
            stage_vld_q <= 1'b0;
        end
    end

    // One history register per slot; the first SYNC_SLOTS reset to the sync word.
    for (genvar g = 0; g < SF_PER_MF; g++) begin : g_hist
        localparam logic [MSG_BITS-1:0] RST_VAL = (g < SYNC_SLOTS) ? SYNC_MSG : '0;

        // Purpose: remember the staged byte used in this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q[g] <= RST_VAL;
            end else if (sf_start && stage_vld_q && (sf_num == SF_W'(g))) begin
                hist_q[g] <= stage_q;
            end
        end
    end

    // Purpose: select the history entry of the starting superframe.
    always_comb begin
        hist_sel = '0;
        for (int i = 0; i < SF_PER_MF; i++) begin
            if (sf_num == SF_W'(i)) begin
                hist_sel = hist_q[i];
            end
        end
    end

    // Purpose: load the active message and underrun state at a superframe start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= '0;
            underrun_q <= 1'b0;
        end else if (sf_start) begin
            active_q   <= stage_vld_q ? stage_q : hist_sel;
            underrun_q <= !stage_vld_q;
        end
    end

    assign active_msg = active_q;
    assign underrun   = underrun_q;

endmodule

// File: rtl/fsmi_fbit_out.sv
// Module: framing-bit output stage.
// On each tick registers the framing bit, the frame index and the position kind.
// Terminal positions take the alternation value, signalling positions take one
// bit of the active message. Assumes active_msg is stable over signalling positions.
module fsmi_fbit_out #(
    parameter int IDX_W    = 7,
    parameter int MSG_BITS = 6,
    localparam int SEL_W   = $clog2(MSG_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [IDX_W-1:0]    frame_num,
    input  logic                is_fs,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic                ft_val,
    input  logic [MSG_BITS-1:0] active_msg,
    output logic                fbit,
    output logic [IDX_W-1:0]    frame_idx,
    output logic                fs_pos
);

    import fsmi_pkg::*;

    fb_kind_e kind;
    logic     msg_bit;
    logic     next_bit;

    // Purpose: pick the selected message bit.
    always_comb begin
        msg_bit = 1'b0;
        for (int i = 0; i < MSG_BITS; i++) begin
            if (bit_sel == SEL_W'(i)) begin
                msg_bit = active_msg[i];
            end
        end
    end

    // Purpose: choose the framing bit by position kind.
    always_comb begin
        kind = is_fs ? FB_SIGNAL : FB_TERMINAL;
        case (kind)
            FB_SIGNAL:   next_bit = msg_bit;
            default:     next_bit = ft_val;
        endcase
    end

    // Purpose: register the outputs of the frame that was ticked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbit      <= 1'b0;
            frame_idx <= '0;
            fs_pos    <= 1'b0;
        end else if (tick) begin
            fbit      <= next_bit;
            frame_idx <= frame_num;
            fs_pos    <= is_fs;
        end
    end

endmodule

// File: rtl/fs_msg_framer.sv
// Module: multiframe framing-bit message inserter (top).
// Generates one framing bit per frame tick: terminal alternation in even frames,
// host message bits (six per superframe, LSB first) in odd frames.
// Assumes frame_tick is a one-cycle pulse per frame and the host stages each
// superframe's byte during the superframe before it.
module fs_msg_framer #(
    parameter int FRAMES_PER_SF = 12,
    parameter int SF_PER_MF     = 6,
    parameter int BYTE_W        = 8,
    parameter int SYNC_SLOTS    = 2,
    localparam int FRAMES_PER_MF = FRAMES_PER_SF * SF_PER_MF,
    localparam int MSG_BITS      = FRAMES_PER_SF / 2,
    localparam int IDX_W         = $clog2(FRAMES_PER_MF),
    localparam int SF_W          = $clog2(SF_PER_MF),
    localparam int SEL_W         = $clog2(MSG_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              host_valid,
    input  logic [BYTE_W-1:0] host_data,
    output logic              host_ready,
    output logic              fbit,
    output logic [IDX_W-1:0]  frame_idx,
    output logic              fs_pos,
    output logic              underrun
);

    logic [IDX_W-1:0]    frame_num;
    logic [SF_W-1:0]     sf_num;
    logic [SEL_W-1:0]    bit_sel;
    logic                is_fs;
    logic                sf_start;
    logic                ft_val;
    logic [MSG_BITS-1:0] active_msg;

    fsmi_frame_seq #(
        .FRAMES_PER_SF (FRAMES_PER_SF),
        .SF_PER_MF     (SF_PER_MF)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (frame_tick),
        .frame_num (frame_num),
        .sf_num    (sf_num),
        .bit_sel   (bit_sel),
        .is_fs     (is_fs),
        .sf_start  (sf_start),
        .ft_val    (ft_val)
    );

    fsmi_slot_store #(
        .SF_PER_MF  (SF_PER_MF),
        .MSG_BITS   (MSG_BITS),
        .BYTE_W     (BYTE_W),
        .SYNC_SLOTS (SYNC_SLOTS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sf_start   (sf_start),
        .sf_num     (sf_num),
        .wr_valid   (host_valid),
        .wr_data    (host_data),
        .wr_ready   (host_ready),
        .active_msg (active_msg),
        .underrun   (underrun)
    );

    fsmi_fbit_out #(
        .IDX_W    (IDX_W),
        .MSG_BITS (MSG_BITS)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (frame_tick),
        .frame_num  (frame_num),
        .is_fs      (is_fs),
        .bit_sel    (bit_sel),
        .ft_val     (ft_val),
        .active_msg (active_msg),
        .fbit       (fbit),
        .frame_idx  (frame_idx),
        .fs_pos     (fs_pos)
    );

endmodule

// File: rtl/fsmi_checker.sv
// Module: property checker for fs_msg_framer, bound to every instance of the top.
// Observes the ports and the superframe-start pulse of the sequencer.
module fsmi_checker #(
    parameter int IDX_W         = 7,
    parameter int FRAMES_PER_MF = 72
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             host_valid,
    input logic             host_ready,
    input logic             sf_start,
    input logic             fbit,
    input logic [IDX_W-1:0] frame_idx,
    input logic             fs_pos,
    input logic             underrun
);

    // R2: terminal positions follow the alternation set by the frame index.
    p_ft_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (fs_pos || (fbit == !frame_idx[1])));

    // R4: an accepted byte fills the stage, so the port is busy next cycle.
    p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> !host_ready);

    // R5: the port only reopens after a superframe start.
    p_ready_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> $past(sf_start));

    // R7: underrun changes only at a superframe start.
    p_underrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_start |=> $stable(underrun));

    // R9: position kind follows index parity.
    p_fs_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (fs_pos == frame_idx[0]));

    // R9: index wraps at the multiframe end.
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && (frame_idx == IDX_W'(FRAMES_PER_MF - 1))) |=> (frame_idx == '0));

    // R10: outputs hold without a tick.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(fbit) && $stable(frame_idx) && $stable(fs_pos)));

endmodule

bind fs_msg_framer fsmi_checker #(
    .IDX_W         (IDX_W),
    .FRAMES_PER_MF (FRAMES_PER_MF)
) u_fsmi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .sf_start   (sf_start),
    .fbit       (fbit),
    .frame_idx  (frame_idx),
    .fs_pos     (fs_pos),
    .underrun   (underrun)
);

// File: tb/tb_fs_msg_framer.sv
`timescale 1ns/1ps
// Bench for fs_msg_framer: behavioural model stepped on each rising edge,
// all outputs compared on each falling edge.
module tb_fs_msg_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       host_valid = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_ready;
    logic       fbit;
    logic [6:0] frame_idx;
    logic       fs_pos;
    logic       underrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fs_msg_framer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .host_valid (host_valid),
        .host_data  (host_data),
        .host_ready (host_ready),
        .fbit       (fbit),
        .frame_idx  (frame_idx),
        .fs_pos     (fs_pos),
        .underrun   (underrun)
    );

    // ---------------- reference model ----------------
    int       m_nf, m_fidx, m_fill;
    bit       m_fbit, m_fs, m_und, m_staged, m_acc, m_prev_tick, m_prev_bnd;
    bit [5:0] m_stage, m_active;
    bit [5:0] m_hist [6];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_nf = 0; m_fidx = 0; m_fill = 0;
            m_fbit = 0; m_fs = 0; m_und = 0; m_staged = 0; m_acc = 0;
            m_prev_tick = 0; m_prev_bnd = 0;
            m_stage = 0; m_active = 0;
            foreach (m_hist[i]) m_hist[i] = (i < 2) ? 6'b111000 : 6'b000000;
        end else begin
            m_prev_tick = frame_tick;
            m_prev_bnd  = 0;
            m_acc       = host_valid && !m_staged;
            if (frame_tick) begin
                if (m_nf % 12 == 0) begin
                    if (m_staged) begin
                        m_hist[m_nf / 12] = m_stage;
                        m_active = m_stage;
                        m_und = 0;
                    end else begin
                        m_active = m_hist[m_nf / 12];
                        m_und = 1;
                    end
                    m_staged   = 0;
                    m_fill     = (m_nf / 12 + 1) % 6;
                    m_prev_bnd = 1;
                end
                if (m_nf % 2 == 0) m_fbit = ((m_nf / 2) % 2 == 0);
                else               m_fbit = m_active[((m_nf % 12) - 1) / 2];
                m_fidx = m_nf;
                m_fs   = (m_nf % 2 == 1);
                m_nf   = (m_nf + 1) % 72;
            end
            if (m_acc) begin
                m_stage  = host_data[5:0];
                m_staged = 1;
            end
        end
    end

    // ---------------- checking ----------------
    string data_tag = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t;
        if (!m_prev_tick)       t = "R10";
        else if (!m_fs)         t = "R2";
        else if (m_und)         t = (m_fidx / 12 < 2) ? "R8" : "R7";
        else                    t = data_tag;
        check(fbit == m_fbit, t, "fbit", fbit, m_fbit);
        check(frame_idx == 7'(m_fidx), m_prev_tick ? "R9" : "R10", "frame_idx", frame_idx, m_fidx);
        check(fs_pos == m_fs, "R9", "fs_pos", fs_pos, m_fs);
        check(underrun == m_und, "R7", "underrun", underrun, m_und);
        check(host_ready == !m_staged, m_prev_bnd ? "R5" : "R4", "host_ready", host_ready, !m_staged);
    endtask

    // ---------------- stimulus ----------------
    logic [31:0] seed = 32'h1234_5678;

    // mode 0: host idle, 1: prompt writer honouring skip mask, 2: writes in the boundary cycle
    task automatic run_phase(input int frames, input int gap, input int mode,
                             input bit [5:0] skip, input string tag);
        data_tag = tag;
        for (int f = 0; f < frames; f++) begin
            for (int c = 0; c < gap; c++) begin
                @(negedge clk);
                compare_all();
                frame_tick = (c == gap - 1);
                if (host_valid && m_acc) host_valid = 1'b0;
                if (mode == 0) begin
                    host_valid = 1'b0;
                end else if (!host_valid && !m_staged) begin
                    if ((mode == 1 && !skip[m_fill]) ||
                        (mode == 2 && frame_tick && (m_nf % 12 == 0))) begin
                        seed = seed * 32'd1664525 + 32'd1013904223;
                        host_data  = seed[31:24];
                        host_valid = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        compare_all();
        frame_tick = 1'b0;
        host_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(fbit == 1'b0,        "R1", "fbit",       fbit, 0);
        check(frame_idx == 7'd0,   "R1", "frame_idx",  frame_idx, 0);
        check(fs_pos == 1'b0,      "R1", "fs_pos",     fs_pos, 0);
        check(underrun == 1'b0,    "R1", "underrun",   underrun, 0);
        check(host_ready == 1'b1,  "R1", "host_ready", host_ready, 1);
        rst_n = 1'b1;
        run_phase(80,  3, 0, 6'b000000, "R8");   // R8: history only, sync in slots 0 and 1
        run_phase(150, 4, 1, 6'b000000, "R6");   // R3 / R6: random bytes, junk upper bits
        run_phase(150, 2, 1, 6'b010100, "R7");   // R7: skipped slots repeat history
        run_phase(80,  3, 2, 6'b000000, "R5");   // R5: write in the boundary cycle
        run_phase(150, 1, 1, 6'b000000, "R3");   // R3: back-to-back ticks
        repeat (4) begin
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule